// File: doc/BRIEF.md
# Peripheral Bus Control Register Block

This block is the software-facing register front end of a four-port peripheral bus controller. A processor reaches it through a simple 32-bit slave port with a byte address and separate read and write strobes. The block keeps the base address of the DMA command list, an enable flag, a reply timeout and the link speed field. It passes these values on to the list engine. It also turns a write of the start command into a single-cycle start pulse for that engine.

Three kinds of access raise a one-cycle debug pulse: a start command while the controller is disabled, an unsupported command value, and an access outside the mapped offsets. None of these pulses changes any stored value. A reset command written to its own offset disables the controller. The status register always reads as idle, because the engine in this system completes a list before software can poll.

Reads are registered. Read data is valid in the cycle after the read strobe and is zero otherwise. A write takes effect at the clock edge that samples it. Every pulse output is high for exactly the cycle after that edge.

Top module: `pbus_regfile`

## Requirements
- R1: While the synchronous reset is high, and at the first edge after it is released, the list base, enable, timeout, speed, read data and every pulse output are zero.
- R2: A write to byte offset 0x04 stores all 32 data bits as the list base. The list base drives `list_base_o` and reads back unchanged at offset 0x04.
- R3: A write to offset 0x14 stores data bit 0 as the enable flag. A read of 0x14 returns the flag in bit 0 and zeros in bits 31:1.
- R4: A write of the value 1 to offset 0x18 while enable is set raises `start_o` for exactly one cycle, the cycle after the write. A write of 0 to 0x18 raises no output and changes no state.
- R5: A write of 1 to offset 0x18 while enable is clear raises `noen_err_o` for one cycle and does not raise `start_o`.
- R6: A write to offset 0x18 of any value other than 0 or 1 raises `badval_o` for one cycle and does not raise `start_o`.
- R7: A read of offset 0x18 always returns zero, which means idle.
- R8: A write to offset 0x80 stores data bits 31:16 as the timeout and bits 9:8 as the speed field. A read of 0x80 returns both fields in the same bit positions, with all other bits zero.
- R9: A write of 0x6155404F to offset 0x8C clears enable and leaves the other registers unchanged, with no pulse raised. A read of 0x8C returns zero and is not flagged as unmapped.
- R10: A write of any other value to offset 0x8C also clears enable, and in addition raises `badval_o` for one cycle.
- R11: A read or write at any byte address other than 0x04, 0x14, 0x18, 0x80 and 0x8C (this includes misaligned addresses) raises `unmapped_o` for one cycle, returns zero read data and changes no stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Byte address within the 0x100-byte window |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_i` |
| list_base_o | output | 32 | DMA command list base address |
| enable_o | output | 1 | Controller enable flag |
| timeout_o | output | 16 | Reply timeout value |
| speed_o | output | 2 | Stored link speed field |
| start_o | output | 1 | One-cycle start pulse to the list engine |
| noen_err_o | output | 1 | Start command seen while disabled |
| badval_o | output | 1 | Unsupported value written to a command register |
| unmapped_o | output | 1 | Access at an unmapped address |

## Verification
Two sweeps cover the whole window. The first writes a data pattern derived from the address to every one of the 256 byte addresses. The second reads every byte address back. Together they tell the five mapped offsets apart from every unmapped or misaligned neighbour, show that unmapped writes leave the stored values alone, and drive the command registers with unsupported values. Directed writes then send the start command with enable set and with enable clear. They also write the command value 0, and write the reset offset once with the magic word and once without it. These cases separate a real start from the not-enabled error and a silent write, and show that an enable clear alone differs from an enable clear with an error pulse.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam logic [31:0] MAGIC_RESET = 32'h6155_404F;

    localparam logic [7:0] OFS_BASE  = 8'h04;
    localparam logic [7:0] OFS_ENAB  = 8'h14;
    localparam logic [7:0] OFS_STATE = 8'h18;
    localparam logic [7:0] OFS_TMO   = 8'h80;
    localparam logic [7:0] OFS_RSTC  = 8'h8C;

    // one-hot register select
    typedef struct packed {
        logic base;
        logic enab;
        logic state;
        logic tmo;
        logic rstc;
    } sel_t;

    typedef struct packed {
        logic [31:0] base;
        logic        en;
        logic [15:0] tmo;
        logic [1:0]  spd;
        logic        start;
        logic        noen;
        logic        badval;
        logic        unmap;
        logic [31:0] rdata;
    } regs_t;

endpackage

// File: rtl/pbus_addr_decode.sv
module pbus_addr_decode
    import pbus_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output sel_t              sel_o,
    output logic              hit_o
);
    localparam int PAD_W = ADDR_W - 8;

    logic [7:0] low;
    logic       upper_zero;

    assign low = addr_i[7:0];

    generate
        if (PAD_W > 0) begin : g_wide
            assign upper_zero = (addr_i[ADDR_W-1:8] == '0);
        end else begin : g_narrow
            assign upper_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        sel_o.base  = upper_zero && (low == OFS_BASE);
        sel_o.enab  = upper_zero && (low == OFS_ENAB);
        sel_o.state = upper_zero && (low == OFS_STATE);
        sel_o.tmo   = upper_zero && (low == OFS_TMO);
        sel_o.rstc  = upper_zero && (low == OFS_RSTC);
        hit_o       = |sel_o;
    end
endmodule

// File: rtl/pbus_read_mux.sv
module pbus_read_mux
    import pbus_pkg::*;
(
    input  sel_t        sel_i,
    input  logic [31:0] base_i,
    input  logic        en_i,
    input  logic [15:0] tmo_i,
    input  logic [1:0]  spd_i,
    output logic [31:0] rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (sel_i.base) rdata_o = base_i;
        if (sel_i.enab) rdata_o = {31'b0, en_i};
        if (sel_i.tmo)  rdata_o = {tmo_i, 6'b0, spd_i, 8'b0};
        // state and reset-command offsets read as zero
    end
endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile
    import pbus_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic [31:0]       list_base_o,
    output logic              enable_o,
    output logic [15:0]       timeout_o,
    output logic [1:0]        speed_o,
    output logic              start_o,
    output logic              noen_err_o,
    output logic              badval_o,
    output logic              unmapped_o
);
    sel_t        sel;
    logic        hit;
    logic [31:0] rmux;
    regs_t       r_d, r_q;

    pbus_addr_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr_i (addr_i),
        .sel_o  (sel),
        .hit_o  (hit)
    );

    pbus_read_mux rmux_i (
        .sel_i   (sel),
        .base_i  (r_q.base),
        .en_i    (r_q.en),
        .tmo_i   (r_q.tmo),
        .spd_i   (r_q.spd),
        .rdata_o (rmux)
    );

    always_comb begin
        r_d        = r_q;
        r_d.start  = 1'b0;
        r_d.noen   = 1'b0;
        r_d.badval = 1'b0;
        r_d.unmap  = 1'b0;
        r_d.rdata  = '0;
        if (wr_i) begin
            if (!hit) r_d.unmap = 1'b1;
            if (sel.base) r_d.base = wdata_i;
            if (sel.enab) r_d.en = wdata_i[0];
            if (sel.state) begin
                if (wdata_i == 32'd1) begin
                    if (r_q.en) r_d.start = 1'b1;
                    else        r_d.noen  = 1'b1;
                end else if (wdata_i != 32'd0) begin
                    r_d.badval = 1'b1;
                end
            end
            if (sel.tmo) begin
                r_d.tmo = wdata_i[31:16];
                r_d.spd = wdata_i[9:8];
            end
            if (sel.rstc) begin
                r_d.en = 1'b0;
                if (wdata_i != MAGIC_RESET) r_d.badval = 1'b1;
            end
        end
        if (rd_i) begin
            r_d.rdata = rmux;
            if (!hit) r_d.unmap = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) r_q <= '0;
        else       r_q <= r_d;
    end

    assign rdata_o     = r_q.rdata;
    assign list_base_o = r_q.base;
    assign enable_o    = r_q.en;
    assign timeout_o   = r_q.tmo;
    assign speed_o     = r_q.spd;
    assign start_o     = r_q.start;
    assign noen_err_o  = r_q.noen;
    assign badval_o    = r_q.badval;
    assign unmapped_o  = r_q.unmap;
endmodule

// File: rtl/pbus_regfile_chk.sv
module pbus_regfile_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_i,
    input logic              rd_i,
    input logic [31:0]       wdata_i,
    input logic [31:0]       rdata_o,
    input logic [31:0]       list_base_o,
    input logic              enable_o,
    input logic [15:0]       timeout_o,
    input logic              start_o,
    input logic              noen_err_o,
    input logic              unmapped_o
);
    assert_start_needs_enable_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        start_o |-> $past(enable_o));

    assert_start_excl_error_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !(start_o && noen_err_o));

    assert_state_reads_idle_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rd_i && addr_i == ADDR_W'(8'h18)) |-> rdata_o == 32'd0);

    assert_timeout_written_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(wr_i && addr_i == ADDR_W'(8'h80)) |-> timeout_o == $past(wdata_i[31:16]));

    assert_reset_cmd_disables_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(wr_i && addr_i == ADDR_W'(8'h8C)) |-> !enable_o);

    assert_unmapped_keeps_state_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        unmapped_o |-> ($stable(list_base_o) && $stable(enable_o) && $stable(timeout_o)));
endmodule

bind pbus_regfile pbus_regfile_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .addr_i      (addr_i),
    .wr_i        (wr_i),
    .rd_i        (rd_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .list_base_o (list_base_o),
    .enable_o    (enable_o),
    .timeout_o   (timeout_o),
    .start_o     (start_o),
    .noen_err_o  (noen_err_o),
    .unmapped_o  (unmapped_o)
);

// File: tb/pbus_regfile_tb_top.sv
`timescale 1ns/1ps
module pbus_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  addr;
    logic        wr, rd;
    logic [31:0] wdata;
    logic [31:0] rdata, list_base;
    logic        enable, start, noen, badval, unmap;
    logic [15:0] timeout;
    logic [1:0]  speed;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] m_base;
    logic        m_en;
    logic [15:0] m_tmo;
    logic [1:0]  m_spd;

    always #4 clk = ~clk;

    pbus_regfile #(.ADDR_W(8)) dut_i (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .wr_i(wr), .rd_i(rd),
        .wdata_i(wdata), .rdata_o(rdata), .list_base_o(list_base),
        .enable_o(enable), .timeout_o(timeout), .speed_o(speed),
        .start_o(start), .noen_err_o(noen), .badval_o(badval),
        .unmapped_o(unmap)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit mapped(input logic [7:0] a);
        return a == 8'h04 || a == 8'h14 || a == 8'h18 || a == 8'h80 || a == 8'h8C;
    endfunction

    task automatic check_state(input string req);
        check({req, " base"}, list_base, m_base);
        check({req, " enable"}, {31'b0, enable}, {31'b0, m_en});
        check({req, " timeout"}, {16'b0, timeout}, {16'b0, m_tmo});
        check({req, " speed"}, {30'b0, speed}, {30'b0, m_spd});
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input string req);
        logic e_start, e_noen, e_bad, e_unmap;
        e_unmap = !mapped(a);
        e_start = (a == 8'h18) && (d == 32'd1) && m_en;
        e_noen  = (a == 8'h18) && (d == 32'd1) && !m_en;
        e_bad   = ((a == 8'h18) && (d > 32'd1)) || ((a == 8'h8C) && (d != 32'h6155404F));
        if (a == 8'h04) m_base = d;
        if (a == 8'h14) m_en = d[0];
        if (a == 8'h80) begin m_tmo = d[31:16]; m_spd = d[9:8]; end
        if (a == 8'h8C) m_en = 1'b0;
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        check({req, " start"}, {31'b0, start}, {31'b0, e_start});
        check({req, " noen"}, {31'b0, noen}, {31'b0, e_noen});
        check({req, " badval"}, {31'b0, badval}, {31'b0, e_bad});
        check({req, " unmapped"}, {31'b0, unmap}, {31'b0, e_unmap});
        check_state(req);
        @(negedge clk);
        check({req, " pulses one cycle"}, {28'b0, start, noen, badval, unmap}, 32'd0);
    endtask

    task automatic do_read(input logic [7:0] a, input string req);
        logic [31:0] e;
        e = 32'd0;
        if (a == 8'h04) e = m_base;
        if (a == 8'h14) e = {31'b0, m_en};
        if (a == 8'h80) e = {m_tmo, 6'b0, m_spd, 8'b0};
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        check({req, " rdata"}, rdata, e);
        check({req, " unmapped"}, {31'b0, unmap}, {31'b0, !mapped(a)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
        m_base = '0; m_en = 1'b0; m_tmo = '0; m_spd = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rdata", rdata, 32'd0);
        check("R1 pulses", {28'b0, start, noen, badval, unmap}, 32'd0);
        check_state("R1");
        rst = 1'b0;
        @(negedge clk);
        check_state("R1 after release");

        // R2 R3 R8 basic mapped registers
        do_write(8'h04, 32'hDEAD_BEEF, "R2");
        do_read (8'h04, "R2");
        do_write(8'h14, 32'hFFFF_FFFF, "R3");
        do_read (8'h14, "R3");
        do_write(8'h80, 32'hA5C3_FFFF, "R8");
        do_read (8'h80, "R8");

        // R4 start with enable, write 0 is silent
        do_write(8'h18, 32'd1, "R4 start");
        do_write(8'h18, 32'd0, "R4 zero");
        do_read (8'h18, "R7");
        // R6 unsupported command value
        do_write(8'h18, 32'd2, "R6");
        // R9 magic reset
        do_write(8'h8C, 32'h6155404F, "R9");
        do_read (8'h8C, "R9");
        // R5 start while disabled
        do_write(8'h18, 32'd1, "R5");
        // R10 non-magic reset word
        do_write(8'h14, 32'd1, "R10 setup");
        do_write(8'h8C, 32'h6155404E, "R10");
        do_read (8'h14, "R10");

        // R11 full write sweep then full read sweep
        for (int a = 0; a < 256; a++) begin
            logic [7:0] b;
            b = 8'(a);
            do_write(b, {b, ~b, b ^ 8'h5A, 8'hC3}, "R11 wsweep");
        end
        do_write(8'h14, 32'd1, "R3 re-enable");
        for (int a = 0; a < 256; a++) begin
            do_read(8'(a), "R11 rsweep");
        end
        do_write(8'h18, 32'd1, "R4 final start");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule